// File: doc/BRIEF.md
# All-Pairs Interaction Index Sequencer

This block walks every ordered pair of distinct atoms `(i, j)` for a run of `N` atoms. It does this with one flattened loop of `N*(N-1)` steps, so a downstream interaction pipeline can take a new pair on every cycle. The outer index `i` moves up by one each time a row ends. A row-position counter `k` runs from 0 to `N-2`. The emitted `j` is `k`, plus one when `k >= i`. This skips the self pair without a triangular nested loop.

Each pair comes with four flags:
- an ordering flag (`i < j`), which downstream logic uses to orient differences and to count each unordered pair once;
- a row-start marker, which clears a per-atom accumulator;
- a row-end marker, which flushes that accumulator;
- a valid strobe.

A downstream ready signal stalls the walk. When the last pair is accepted, a one-cycle done pulse closes the run.

Top module: `pair_seq`

## Requirements
- R1: After reset, `pair_valid` and `done` are low.
- R2: A `start` pulse in idle with `num_atoms >= 2` latches the count. On the next cycle it presents the pair (0, 1) with `pair_valid` high.
- R3: One run presents exactly `N*(N-1)` accepted pairs. They come in row-major order: `i` rises from 0 to N-1, and within a row `j` rises over every value from 0 to N-1 except `i`.
- R4: Within a row, the k-th pair (k from 0) has `j = k` when `k < i` and `j = k+1` otherwise, so `j` never equals `i`.
- R5: `i_below_j` is 1 exactly when the presented `i` is less than the presented `j`.
- R6: `row_first` is 1 on the first pair of each row (k = 0). `row_last` is 1 on the last pair of each row (k = N-2). For N = 2, both are 1 on every pair.
- R7: While `pair_valid` is high and `ready` is low, the pair, its flags and `pair_valid` hold unchanged into the next cycle.
- R8: `done` is high for exactly one cycle, the cycle after the final pair is accepted. `pair_valid` is low in that cycle, and the block is then idle.
- R9: A `start` with `num_atoms` of 0 or 1 produces a `done` pulse on the next cycle and no valid pair.
- R10: A `start` pulse during a run is ignored. The run continues unchanged with its latched count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (sampled when idle) |
| num_atoms | input | W | Atom count N for the run |
| ready | input | 1 | Downstream accepts the presented pair |
| idx_i | output | W | Outer atom index |
| idx_j | output | W | Inner atom index |
| i_below_j | output | 1 | idx_i < idx_j |
| row_first | output | 1 | First pair of the row |
| row_last | output | 1 | Last pair of the row |
| pair_valid | output | 1 | A pair is presented |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
A wrong row counter or outer index shows up at the ports on the first pair that follows it. That pair is out of row-major order, or it is a self pair, or its markers are misplaced, so a per-pair comparison catches it in the same cycle. A wrong end condition shows up later, when the run ends: the count of accepted pairs differs from `N*(N-1)`, or `done` comes early, comes late, or lasts more than one cycle. The sweep covers every N from 2 to 6, with continuous and gapped ready patterns, plus degenerate starts and a start during a run.

// File: rtl/pair_seq.sv
module pair_seq #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] num_atoms,
  input  logic         ready,
  output logic [W-1:0] idx_i,
  output logic [W-1:0] idx_j,
  output logic         i_below_j,
  output logic         row_first,
  output logic         row_last,
  output logic         pair_valid,
  output logic         done
);

  logic [W-1:0] n_q, i_q, k_q;
  logic         busy, done_q;
  logic         k_end, i_end, step;

  assign k_end = (k_q == n_q - W'(2));
  assign i_end = (i_q == n_q - W'(1));
  assign step  = busy && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_q    <= '0;
      i_q    <= '0;
      k_q    <= '0;
      busy   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy) begin
        if (start) begin
          n_q <= num_atoms;
          i_q <= '0;
          k_q <= '0;
          if (num_atoms < W'(2)) done_q <= 1'b1;
          else                   busy   <= 1'b1;
        end
      end else if (step) begin
        if (k_end) begin
          k_q <= '0;
          i_q <= i_q + W'(1);
          if (i_end) begin
            busy   <= 1'b0;
            done_q <= 1'b1;
          end
        end else begin
          k_q <= k_q + W'(1);
        end
      end
    end
  end

  assign idx_i      = i_q;
  assign idx_j      = (k_q >= i_q) ? k_q + W'(1) : k_q;
  assign i_below_j  = (k_q >= i_q);
  assign row_first  = busy && (k_q == '0);
  assign row_last   = busy && k_end;
  assign pair_valid = busy;
  assign done       = done_q;

  assert_no_self_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> (idx_i != idx_j));

  assert_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> (idx_i < n_q && idx_j < n_q));

  assert_order_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> (i_below_j == (idx_i < idx_j)));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && !ready) |=> (pair_valid && $stable(idx_i) && $stable(idx_j)
                                && $stable(row_first) && $stable(row_last)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_no_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !pair_valid);

endmodule

// File: tb/pair_seq_tb_top.sv
module pair_seq_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] num_atoms = '0;
  logic         ready = 1'b1;
  logic [W-1:0] idx_i, idx_j;
  logic         i_below_j, row_first, row_last, pair_valid, done;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pair_seq #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .num_atoms(num_atoms),
    .ready(ready), .idx_i(idx_i), .idx_j(idx_j), .i_below_j(i_below_j),
    .row_first(row_first), .row_last(row_last), .pair_valid(pair_valid),
    .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_n(input int n, input int mode);
    int ei, ej, cnt, cyc, hi, hj;
    bit held, seen_done;
    ei = 0; ej = 1; cnt = 0; cyc = 0; held = 0; seen_done = 0;
    @(negedge clk);
    start = 1'b1; num_atoms = W'(n);
    @(negedge clk);
    start = 1'b0;
    chk(pair_valid && idx_i == 0 && idx_j == 1, "R2 first pair", {idx_i, idx_j}, 1);
    while (!seen_done && cyc < 2000) begin
      if (held) begin
        chk(pair_valid && idx_i == hi && idx_j == hj, "R7 stall hold", idx_j, hj);
        held = 0;
      end
      if (done) begin
        seen_done = 1;
        chk(!pair_valid, "R8 valid low with done", pair_valid, 0);
        chk(cnt == n * (n - 1), "R3 pair count", cnt, n * (n - 1));
      end else begin
        chk(pair_valid, "R3 valid during run", pair_valid, 1);
        chk(idx_i == ei && idx_j == ej, "R3 R4 pair order", idx_i * 256 + idx_j, ei * 256 + ej);
        chk(i_below_j == (ei < ej), "R5 order flag", i_below_j, ei < ej);
        chk(row_first == (ej == ((ei == 0) ? 1 : 0)), "R6 row_first", row_first, ej == ((ei == 0) ? 1 : 0));
        chk(row_last == (ej == ((ei == n - 1) ? n - 2 : n - 1)), "R6 row_last", row_last, ej == ((ei == n - 1) ? n - 2 : n - 1));
        if (mode == 2 && cnt == 3) begin
          start = 1'b1; num_atoms = W'(n + 3);
        end else begin
          start = 1'b0;
        end
        ready = (mode == 1) ? ((cyc % 3) != 1) : 1'b1;
        if (ready) begin
          cnt++;
          ej++;
          if (ej == ei) ej++;
          if (ej >= n) begin
            ei++;
            ej = (ei == 0) ? 1 : 0;
          end
        end else begin
          held = 1; hi = ei; hj = ej;
        end
      end
      cyc++;
      if (!seen_done) @(negedge clk);
    end
    start = 1'b0; ready = 1'b1;
    chk(seen_done, "R8 done seen", seen_done, 1);
    @(negedge clk);
    chk(!done && !pair_valid, "R8 idle after done", {done, pair_valid}, 0);
  endtask

  task automatic run_small(input int n);
    @(negedge clk);
    start = 1'b1; num_atoms = W'(n);
    @(negedge clk);
    start = 1'b0;
    chk(done && !pair_valid, "R9 immediate done", {done, pair_valid}, 2);
    @(negedge clk);
    chk(!done && !pair_valid, "R9 no pairs after", {done, pair_valid}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!pair_valid && !done, "R1 reset state", {pair_valid, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pair_valid && !done, "R1 idle after reset", {pair_valid, done}, 0);
    for (int n = 2; n <= 6; n++) run_n(n, 0);
    for (int n = 2; n <= 6; n++) run_n(n, 1);
    run_n(4, 2); // R10 start during run ignored
    run_n(5, 2); // R10
    run_small(0);
    run_small(1);
    run_n(3, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule